// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block is a 32-bit datapath for saturating arithmetic. Each operation clamps its result to the representable range instead of letting it wrap. An opcode selects the operation and two operands feed it. The result is combinational, so it appears in the same cycle as the inputs.

The supported operations are:
- signed and unsigned add and subtract with clamping;
- an add that wraps but still reports signed overflow;
- a signed doubling of operand A;
- signed and unsigned clamping of operand A to a bit position given on a 5-bit input;
- the same two clamps applied to each 16-bit half of operand A on its own.

Every clamp or overflow produces a saturation event. When the enable is high, the event sets a single sticky flag at the next clock edge. Software-visible control over the flag comes from two synchronous inputs: a clear, and a write that loads a given value. The clear has the highest priority, then the write, then the event.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 is signed add. If A and B share a sign and the wrapped sum's sign differs from A's, the result is 0x7FFFFFFF when A is non-negative and 0x80000000 when A is negative, and an event is raised. Otherwise the result is the sum and no event is raised.
- R2: Opcode 1 is signed subtract A−B. If A and B differ in sign and the wrapped difference's sign differs from A's, the result clamps the same way as in R1 and an event is raised. Otherwise the result is the difference.
- R3: Opcode 2 returns the wrapped sum A+B unchanged. It raises an event exactly when that sum overflows as a signed value.
- R4: Opcode 3 doubles A as a signed value. If A ≥ 0x40000000 the result is 0x7FFFFFFF with an event. If A ≤ 0xC0000000 (signed) the result is 0x80000000 with an event; this includes A = 0xC0000000 itself. Otherwise the result is A shifted left by one. B is ignored.
- R5: Opcode 4 is unsigned add and gives 0xFFFFFFFF with an event on carry-out. Opcode 5 is unsigned subtract and gives 0 with an event on borrow.
- R6: Opcode 6 clamps signed A into the range −2^n to 2^n−1, where n is the position input (0 to 31). An event is raised when the bits of A from n upward are neither all zero nor all one.
- R7: Opcode 7 clamps signed A into the range 0 to 2^n−1. Negative inputs give 0 and inputs above the limit give 2^n−1; both cases raise an event.
- R8: Opcodes 8 (signed) and 9 (unsigned) split A into halves, bits 15:0 and 31:16. Each half is treated as a signed 16-bit value and clamped as in R6 or R7. The low 16 bits of each lane's result go into the same half of the output. An event is raised if either lane clamps.
- R9: With the enable high, an event sets the sticky flag at the next rising edge. With the enable low, an event leaves the flag unchanged. Once set, the flag holds until a clear or a write.
- R10: A high synchronous clear zeroes the flag at the next edge, regardless of the write input or any event. Without a clear, a high write loads the write-data bit, regardless of any event.
- R11: During and after an asynchronous active-low reset the flag is 0.
- R12: Opcodes 10 to 15 give a result of 0 and never raise an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Allows a saturation event to set the flag |
| op | input | 4 | Operation select |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B |
| pos | input | 5 | Clamp bit position n |
| q_clr | input | 1 | Synchronous clear of the flag |
| q_wr | input | 1 | Synchronous write of the flag |
| q_wdata | input | 1 | Value loaded by a write |
| result | output | 32 | Operation result |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
A saturation event and a clear or write of the sticky flag can land in the same cycle. This is the case where the flag's priority order decides the outcome. The bench provokes it by applying an overflowing signed add with the enable high while asserting the clear, then the write with each data value, then both together. It judges the flag one edge later against the order clear, then write, then event. Around each arithmetic vector the bench also clears the flag first. It then checks that the flag taken from that single operation matches the saturation computed by the bench's wide-integer model.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_QADD   = 4'd2,
    OP_SDBL   = 4'd3,
    OP_UADD   = 4'd4,
    OP_USUB   = 4'd5,
    OP_SCLP   = 4'd6,
    OP_UCLP   = 4'd7,
    OP_SCLP2  = 4'd8,
    OP_UCLP2  = 4'd9
  } sat_op_e;

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    res,
  output logic            evt
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  // Rail chosen by the sign of operand A.
  function automatic logic [W-1:0] rail(input logic a_neg);
    return a_neg ? SMIN : SMAX;
  endfunction

  // Signed overflow: result sign left A's sign while operand signs relate as the op requires.
  function automatic logic sovf(input logic a_msb, input logic b_msb,
                                input logic r_msb, input logic is_sub);
    return (r_msb != a_msb) && ((a_msb != b_msb) == is_sub);
  endfunction

  // Doubling limits: at or above quarter-range positive, at or below quarter-range negative.
  function automatic logic dbl_hi(input logic [W-1:0] v);
    return !v[W-1] && v[W-2];
  endfunction

  function automatic logic dbl_lo(input logic [W-1:0] v);
    return v[W-1] && (!v[W-2] || (v[W-3:0] == '0));
  endfunction

  logic [W-1:0] sum_w, dif_w;
  logic [W:0]   usum, udif;
  logic         add_ovf, sub_ovf;

  assign sum_w   = a + b;
  assign dif_w   = a - b;
  assign usum    = {1'b0, a} + {1'b0, b};
  assign udif    = {1'b0, a} - {1'b0, b};
  assign add_ovf = sovf(a[W-1], b[W-1], sum_w[W-1], 1'b0);
  assign sub_ovf = sovf(a[W-1], b[W-1], dif_w[W-1], 1'b1);

  always_comb begin
    res = '0;
    evt = 1'b0;
    case (op)
      OP_SADD: begin
        res = add_ovf ? rail(a[W-1]) : sum_w;
        evt = add_ovf;
      end
      OP_SSUB: begin
        res = sub_ovf ? rail(a[W-1]) : dif_w;
        evt = sub_ovf;
      end
      OP_QADD: begin
        res = sum_w;
        evt = add_ovf;
      end
      OP_SDBL: begin
        if (dbl_hi(a)) begin
          res = SMAX;
          evt = 1'b1;
        end else if (dbl_lo(a)) begin
          res = SMIN;
          evt = 1'b1;
        end else begin
          res = {a[W-2:0], 1'b0};
        end
      end
      OP_UADD: begin
        res = usum[W] ? '1 : usum[W-1:0];
        evt = usum[W];
      end
      OP_USUB: begin
        res = udif[W] ? '0 : udif[W-1:0];
        evt = udif[W];
      end
      default: begin
        res = '0;
        evt = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int IN_W  = 32,
  parameter int POS_W = 5
) (
  input  logic [IN_W-1:0]  val,
  input  logic [POS_W-1:0] pos,
  input  logic             uns,
  output logic [IN_W-1:0]  res,
  output logic             evt
);

  // Low-bit mask of width pos; all ones once pos reaches the lane width.
  function automatic logic [IN_W-1:0] low_mask(input logic [POS_W-1:0] p);
    return ~({IN_W{1'b1}} << p);
  endfunction

  logic [IN_W-1:0] top;
  logic [IN_W-1:0] mask;
  logic            neg, top_zero, top_ones;

  assign top      = IN_W'($signed(val) >>> pos);
  assign mask     = low_mask(pos);
  assign neg      = val[IN_W-1];
  assign top_zero = (top == '0);
  assign top_ones = (top == '1);

  always_comb begin
    res = val;
    evt = 1'b0;
    if (uns) begin
      if (neg) begin
        res = '0;
        evt = 1'b1;
      end else if (!top_zero) begin
        res = mask;
        evt = 1'b1;
      end
    end else begin
      if (!neg && !top_zero) begin
        res = mask;
        evt = 1'b1;
      end else if (neg && !top_ones) begin
        res = ~mask;
        evt = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr,
  input  logic wdata,
  input  logic set,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (wr)   q <= wdata;
    else if (set)  q <= 1'b1;
  end

endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [POS_W-1:0]  pos,
  input  logic              q_clr,
  input  logic              q_wr,
  input  logic              q_wdata,
  output logic [DATA_W-1:0] result,
  output logic              q_flag
);

  localparam int NLANES = DATA_W / LANE_W;

  sat_op_e           op_e;
  logic [DATA_W-1:0] res_arith, res_full, res_lane;
  logic              evt_arith, evt_full;
  logic [NLANES-1:0] evt_lane;
  logic              is_uns, is_full, is_lane;
  logic              sat_evt;

  assign op_e    = sat_op_e'(op);
  assign is_uns  = (op_e == OP_UCLP) || (op_e == OP_UCLP2);
  assign is_full = (op_e == OP_SCLP) || (op_e == OP_UCLP);
  assign is_lane = (op_e == OP_SCLP2) || (op_e == OP_UCLP2);

  sat_addsub #(.W(DATA_W)) u_addsub (
    .op  (op),
    .a   (a),
    .b   (b),
    .res (res_arith),
    .evt (evt_arith)
  );

  sat_clamp #(.IN_W(DATA_W), .POS_W(POS_W)) u_clamp_full (
    .val (a),
    .pos (pos),
    .uns (is_uns),
    .res (res_full),
    .evt (evt_full)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    sat_clamp #(.IN_W(LANE_W), .POS_W(POS_W)) u_clamp_lane (
      .val (a[g*LANE_W +: LANE_W]),
      .pos (pos),
      .uns (is_uns),
      .res (res_lane[g*LANE_W +: LANE_W]),
      .evt (evt_lane[g])
    );
  end

  always_comb begin
    if (is_full)      result = res_full;
    else if (is_lane) result = res_lane;
    else              result = res_arith;
  end

  assign sat_evt = is_full ? evt_full : (is_lane ? (|evt_lane) : evt_arith);

  sat_sticky u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (q_clr),
    .wr    (q_wr),
    .wdata (q_wdata),
    .set   (en && sat_evt),
    .q     (q_flag)
  );

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [3:0]        op,
  input logic              q_clr,
  input logic              q_wr,
  input logic              q_wdata,
  input logic [DATA_W-1:0] result,
  input logic              q_flag,
  input logic              sat_evt
);

  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  p_rail_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd0 && sat_evt) |-> (result == SMAX || result == SMIN));

  p_rail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd1 && sat_evt) |-> (result == SMAX || result == SMIN));

  p_nonneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7) |-> !result[DATA_W-1]);

  p_lane_nonneg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd9) |-> (!result[DATA_W-1] && !result[LANE_W-1]));

  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sat_evt && !q_clr && !q_wr) |=> q_flag);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag && !q_clr && !q_wr) |=> q_flag);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_flag && !q_wr && !(en && sat_evt)) |=> !q_flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_clr |=> !q_flag);

  p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_clr && q_wr) |=> (q_flag == $past(q_wdata)));

  p_unused_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 4'd10) |-> (result == '0 && !sat_evt));

  always_comb begin
    if (!rst_n) begin
      a_reset_r11: assert (q_flag == 1'b0);
    end
  end

endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .op      (op),
  .q_clr   (q_clr),
  .q_wr    (q_wr),
  .q_wdata (q_wdata),
  .result  (result),
  .q_flag  (q_flag),
  .sat_evt (sat_evt)
);

// File: tb/sat_alu_tb.sv
`timescale 1ns/1ps
module sat_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  pos = '0;
  logic        q_clr = 1'b0, q_wr = 1'b0, q_wdata = 1'b0;
  logic [31:0] result;
  logic        q_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sat_alu u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b), .pos(pos),
    .q_clr(q_clr), .q_wr(q_wr), .q_wdata(q_wdata),
    .result(result), .q_flag(q_flag)
  );

  function automatic logic [31:0] corner(input int i);
    case (i)
      0:  return 32'h0000_0000;  1:  return 32'h0000_0001;
      2:  return 32'h0000_0002;  3:  return 32'h7FFF_FFFF;
      4:  return 32'h7FFF_FFFE;  5:  return 32'h8000_0000;
      6:  return 32'h8000_0001;  7:  return 32'hFFFF_FFFF;
      8:  return 32'hFFFF_FFFE;  9:  return 32'h4000_0000;
      10: return 32'h3FFF_FFFF;  11: return 32'hC000_0000;
      12: return 32'hC000_0001;  13: return 32'hBFFF_FFFF;
      14: return 32'h0000_8000;  15: return 32'hFFFF_7FFF;
      16: return 32'h7FFF_8000;  17: return 32'h8000_7FFF;
      18: return 32'h00FF_FF00;  default: return 32'h1234_ABCD;
    endcase
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4, 5: return "R5"; 6: return "R6"; 7: return "R7";
      8, 9: return "R8"; default: return "R12";
    endcase
  endfunction

  // Signed clamp on a wide integer; bit 32 is the event.
  function automatic logic [32:0] m_clamp(input longint v, input int p, input bit uns);
    longint hi = (64'sd1 <<< p) - 1;
    longint lo = uns ? 64'sd0 : -(64'sd1 <<< p);
    if (v > hi) return {1'b1, hi[31:0]};
    if (v < lo) return {1'b1, lo[31:0]};
    return {1'b0, v[31:0]};
  endfunction

  function automatic logic [32:0] m_sat32(input longint v);
    if (v > 64'sd2147483647)  return {1'b1, 32'h7FFF_FFFF};
    if (v < -64'sd2147483648) return {1'b1, 32'h8000_0000};
    return {1'b0, v[31:0]};
  endfunction

  function automatic logic [32:0] model(input int o, input logic [31:0] x,
                                        input logic [31:0] y, input int p);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint ux = longint'({32'd0, x});
    longint uy = longint'({32'd0, y});
    longint t;
    logic [32:0] l0, l1;
    case (o)
      0: return m_sat32(sx + sy);
      1: return m_sat32(sx - sy);
      2: begin t = sx + sy; return {m_sat32(t)[32], x + y}; end
      3: begin
           if (sx >= 64'sd1073741824)  return {1'b1, 32'h7FFF_FFFF};
           if (sx <= -64'sd1073741824) return {1'b1, 32'h8000_0000};
           t = sx * 2; return {1'b0, t[31:0]};
         end
      4: begin t = ux + uy; return (t > 64'sd4294967295) ? {1'b1, 32'hFFFF_FFFF} : {1'b0, t[31:0]}; end
      5: begin t = ux - uy; return (t < 0) ? {1'b1, 32'h0} : {1'b0, t[31:0]}; end
      6: return m_clamp(sx, p, 1'b0);
      7: return m_clamp(sx, p, 1'b1);
      8, 9: begin
           l0 = m_clamp(longint'($signed(x[15:0])),  p, o == 9);
           l1 = m_clamp(longint'($signed(x[31:16])), p, o == 9);
           return {l0[32] | l1[32], l1[15:0], l0[15:0]};
         end
      default: return 33'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Clear flag, apply one operation with enable, check result, then the flag it left.
  task automatic run_vec(input int o, input logic [31:0] x, input logic [31:0] y, input int p);
    logic [32:0] e;
    e = model(o, x, y, p);
    @(negedge clk); q_clr = 1'b1; en = 1'b0;
    @(negedge clk); q_clr = 1'b0; en = 1'b1;
    op = 4'(o); a = x; b = y; pos = 5'(p);
    #1 check(tag_of(o), "result", result, e[31:0]);
    @(negedge clk); en = 1'b0;
    check(tag_of(o), "flag", {31'd0, q_flag}, {31'd0, e[32]});
  endtask

  task automatic step_flag(input bit e_in, input bit c, input bit w, input bit wd,
                           input bit sat, input bit exp_q, input string tag);
    @(negedge clk);
    en = e_in; q_clr = c; q_wr = w; q_wdata = wd; op = 4'd0;
    a = sat ? 32'h7FFF_FFFF : 32'd1; b = 32'd1;
    @(negedge clk);
    en = 1'b0; q_clr = 1'b0; q_wr = 1'b0; q_wdata = 1'b0;
    check(tag, "sticky", {31'd0, q_flag}, {31'd0, exp_q});
  endtask

  initial begin
    #1 check("R11", "reset flag", {31'd0, q_flag}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "flag after reset", {31'd0, q_flag}, 32'd0);

    for (int o = 0; o < 6; o++)
      for (int i = 0; i < 20; i++)
        for (int j = 0; j < 20; j++)
          run_vec(o, corner(i), corner(j), 0);

    for (int o = 6; o < 10; o++)
      for (int i = 0; i < 20; i++)
        for (int p = 0; p < 32; p++)
          run_vec(o, corner(i), 32'h5A5A_5A5A, p);

    for (int o = 10; o < 16; o++)
      for (int i = 0; i < 4; i++)
        run_vec(o, corner(i + 3), corner(i + 5), i);

    // Sticky behaviour (R9) and same-cycle priorities (R10).
    step_flag(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    step_flag(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    step_flag(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    step_flag(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    step_flag(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    step_flag(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
    step_flag(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R10");
    step_flag(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
    step_flag(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R10");
    step_flag(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R10");

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule